// File: doc/BRIEF.md
# Serial Controller Interrupt Combiner

This block merges the four interrupt conditions of a serial port controller into one active-high interrupt line. It also produces an 8-bit identification byte that the CPU reads to find out which condition needs attention. The four conditions are a receive line error, receive data ready, transmit holding register empty and a modem status change. The block does not detect these conditions. It takes each one as a level from the neighbouring logic. It holds a 4-bit enable register, and each condition can reach the interrupt line only while its enable bit is set.

The block watches the CPU access strobes that service a condition. These are a line status read, a receive buffer read, a modem status read, a transmit holding write, and a read of the identification byte while it reports transmit empty. After a condition is serviced, it stops contributing to the interrupt, even if its level is still high. It contributes again only after the level has dropped and risen once more. For the error, data-ready and modem sources this covers the cycle or so the upstream detector needs to clear itself. For transmit empty it gives the rule that a serviced empty stays quiet until the holding register next becomes empty.

Both outputs are registered. Each one reflects the source levels, enable writes and service strobes present at the same rising clock edge. An asynchronous active-low reset clears the interrupt line and the enable register.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is asserted, and after reset is released, `irq` is 0 and `iir` is 8'h01. The enable register is cleared by reset, so no condition raises `irq` until enables are written.
- R2: At a clock edge where `ien_we` is 1, `ien_din` is loaded into the enable register. The enable bit mapping is bit 3 line error, bit 2 receive data ready, bit 1 transmit empty and bit 0 modem status. A condition whose enable bit is 0 never raises `irq`.
- R3: `irq` is 1 whenever at least one condition is high, enabled and not serviced.
- R4: `iir[0]` is 0 while an interrupt is pending and 1 otherwise. `iir[7:3]` is always 0. With nothing pending, `iir` is 8'h01.
- R5: `iir[2:1]` names the highest-priority pending source: 11 for line error, 10 for receive data ready, 01 for transmit empty and 00 for modem status, in that priority order.
- R6: `rd_lsr` services the line error. The error stays masked while `line_err` remains high, and it is re-armed once `line_err` has been low at a clock edge.
- R7: `rd_rbr` services receive data ready with the same mask and re-arm behaviour as R6, applied to `rx_ready`.
- R8: `rd_msr` services the modem status source with the same mask and re-arm behaviour as R6, applied to `msr_delta`.
- R9: `wr_thr` services transmit empty. It stays masked until `tx_empty` has gone low and then high again.
- R10: `rd_iir` services transmit empty only when `iir` currently shows 8'h02. A read while another source is reported leaves transmit empty pending.
- R11: An enable write, source level or service strobe present at rising edge k is reflected in `irq` and `iir` right after edge k. A service strobe at an edge where its condition is high masks that condition at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ien_we | input | 1 | Write strobe for the enable register |
| ien_din | input | 4 | Enable register write data |
| line_err | input | 1 | Receive line error condition level |
| rx_ready | input | 1 | Receive data ready condition level |
| tx_empty | input | 1 | Transmit holding register empty level |
| msr_delta | input | 1 | OR of the modem status change flags |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| rd_iir | input | 1 | Identification byte read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| irq | output | 1 | Interrupt line, active high |
| iir | output | 8 | Interrupt identification byte |

## Verification
The assertions assume that every input is a synchronous level, valid at each rising edge, and that a source level falls only after the upstream logic has cleared it. They do not assume that service strobes are one cycle wide. A strobe held high for several edges simply keeps its condition masked. The stimulus changes all inputs only on falling clock edges and holds them stable across the following rising edge. It drives each source either as a steady level or as a single drop and rise, so every mask and re-arm happens at a known edge. Reset is applied both at start-up and in the middle of activity. The synchronizer's two-edge release delay is allowed for before any vector is applied.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  // Number of interrupt sources; the slot index doubles as the priority code.
  localparam int unsigned SRC_N = 4;

  typedef enum logic [1:0] {
    SRC_MSR = 2'd0,   // lowest priority
    SRC_THR = 2'd1,
    SRC_RXA = 2'd2,
    SRC_ERR = 2'd3    // highest priority
  } src_e;
endpackage

// File: rtl/uart_irq_slot.sv
// One interrupt source: enable gating and a service mask that re-arms when
// the source level drops.
module uart_irq_slot (
  input  logic clk,
  input  logic rst_l,
  input  logic cond_i,
  input  logic svc_i,
  input  logic en_i,
  output logic act_o
);
  logic sup_q;
  logic sup_d;

  always_comb begin
    if (cond_i) sup_d = sup_q | svc_i;
    else        sup_d = 1'b0;
    act_o = cond_i & en_i & ~sup_d;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) sup_q <= 1'b0;
    else        sup_q <= sup_d;
  end

  AST_SVC_MASKS: assert property (@(posedge clk) disable iff (!rst_l)
    (cond_i && svc_i) |=> sup_q) else $error("service did not mask"); // R6
  AST_LOW_REARMS: assert property (@(posedge clk) disable iff (!rst_l)
    !cond_i |=> !sup_q) else $error("mask not released"); // R9
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_l)
    (sup_q && cond_i) |=> sup_q) else $error("mask dropped early"); // R7
endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority encoder: the highest set request index wins.
module uart_irq_prio #(
  parameter int unsigned N  = 4,
  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [CW-1:0] code_o
);
  logic [N-1:0] grant;
  logic [N-1:0] above;

  always_comb begin
    above[N-1] = 1'b0;
    for (int i = N - 2; i >= 0; i--) above[i] = above[i+1] | req_i[i+1];
    grant = req_i & ~above;
    code_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code_o = CW'(i);
    end
    valid_o = |req_i;
  end

  always_comb begin
    AST_ONE_WINNER: assert ($onehot0(grant)) else $error("two winners"); // R5
    AST_WINNER_IFF: assert ((|grant) == valid_o) else $error("winner mismatch"); // R4
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned IID_W = 8,
  localparam int unsigned CW = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ien_we,
  input  logic [SRC_N-1:0] ien_din,
  input  logic             line_err,
  input  logic             rx_ready,
  input  logic             tx_empty,
  input  logic             msr_delta,
  input  logic             rd_lsr,
  input  logic             rd_rbr,
  input  logic             rd_iir,
  input  logic             rd_msr,
  input  logic             wr_thr,
  output logic             irq,
  output logic [IID_W-1:0] iir
);
  localparam logic [IID_W-1:0] IDLE_IID = IID_W'(1);
  localparam logic [IID_W-1:0] THR_IID  = IID_W'(int'(SRC_THR) * 2);

  // Reset: asserted asynchronously, released after two edges.
  logic [1:0] rst_sync;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_l = rst_sync[1];

  // Enable register
  logic [SRC_N-1:0] ien_q;
  logic [SRC_N-1:0] ien_d;
  always_comb ien_d = ien_we ? ien_din : ien_q;
  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) ien_q <= '0;
    else        ien_q <= ien_d;
  end

  // Source and service vectors, indexed by priority code
  logic [SRC_N-1:0] cond_v;
  logic [SRC_N-1:0] svc_v;
  logic [SRC_N-1:0] act_v;
  logic             thr_shown;

  always_comb begin
    thr_shown = (iir == THR_IID);
    cond_v = '0;
    svc_v  = '0;
    cond_v[SRC_ERR] = line_err;
    cond_v[SRC_RXA] = rx_ready;
    cond_v[SRC_THR] = tx_empty;
    cond_v[SRC_MSR] = msr_delta;
    svc_v[SRC_ERR]  = rd_lsr;
    svc_v[SRC_RXA]  = rd_rbr;
    svc_v[SRC_THR]  = wr_thr | (rd_iir & thr_shown);
    svc_v[SRC_MSR]  = rd_msr;
  end

  for (genvar g = 0; g < SRC_N; g++) begin : g_slot
    uart_irq_slot u_slot (
      .clk    (clk),
      .rst_l  (rst_l),
      .cond_i (cond_v[g]),
      .svc_i  (svc_v[g]),
      .en_i   (ien_d[g]),
      .act_o  (act_v[g])
    );
  end

  logic          pend;
  logic [CW-1:0] win;
  uart_irq_prio #(.N(SRC_N)) u_prio (
    .req_i   (act_v),
    .valid_o (pend),
    .code_o  (win)
  );

  // Output registers
  logic             irq_d;
  logic [IID_W-1:0] iir_d;
  always_comb begin
    irq_d = |act_v;
    iir_d = '0;
    iir_d[CW:1] = win;
    iir_d[0] = ~pend;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      irq <= 1'b0;
      iir <= IDLE_IID;
    end else begin
      irq <= irq_d;
      iir <= iir_d;
    end
  end

  AST_IDLE_ID: assert property (@(posedge clk) disable iff (!rst_l)
    !irq |-> (iir == IDLE_IID)) else $error("idle id wrong"); // R4
  AST_ID_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_l)
    iir[IID_W-1:CW+1] == '0) else $error("id upper bits set"); // R4
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_l)
    irq |-> (|ien_q)) else $error("irq without enable"); // R2
  AST_THR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_l)
    (rd_iir && thr_shown) |=> (iir != THR_IID)) else $error("id read kept thr"); // R10
endmodule

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ien_we;
  logic [3:0] ien_din;
  logic       line_err, rx_ready, tx_empty, msr_delta;
  logic       rd_lsr, rd_rbr, rd_iir, rd_msr, wr_thr;
  logic       irq;
  logic [7:0] iir;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  uart_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ien_we(ien_we), .ien_din(ien_din),
    .line_err(line_err), .rx_ready(rx_ready), .tx_empty(tx_empty),
    .msr_delta(msr_delta), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr),
    .rd_iir(rd_iir), .rd_msr(rd_msr), .wr_thr(wr_thr),
    .irq(irq), .iir(iir)
  );

  // cnd = {err, rx, thr, msr}; svc = {lsr, rbr, iir, msr, thr}
  typedef struct packed {
    logic       we;
    logic [3:0] din;
    logic [3:0] cnd;
    logic [4:0] svc;
    logic       eirq;
    logic [7:0] eiir;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'h0, 4'b1111, 5'b00000, 1'b0, 8'h01, 4'd1},  // R1 enables cleared
    '{1'b1, 4'h1, 4'b0000, 5'b00000, 1'b0, 8'h01, 4'd2},  // R2
    '{1'b0, 4'h0, 4'b0001, 5'b00000, 1'b1, 8'h00, 4'd3},  // R3 modem
    '{1'b0, 4'h0, 4'b0011, 5'b00000, 1'b1, 8'h00, 4'd2},  // R2 thr disabled
    '{1'b1, 4'hF, 4'b0011, 5'b00000, 1'b1, 8'h02, 4'd5},  // R5
    '{1'b0, 4'h0, 4'b0111, 5'b00000, 1'b1, 8'h04, 4'd5},  // R5
    '{1'b0, 4'h0, 4'b1111, 5'b00000, 1'b1, 8'h06, 4'd5},  // R5
    '{1'b0, 4'h0, 4'b1111, 5'b00100, 1'b1, 8'h06, 4'd10}, // R10 other shown
    '{1'b0, 4'h0, 4'b1111, 5'b10000, 1'b1, 8'h04, 4'd6},  // R6
    '{1'b0, 4'h0, 4'b1111, 5'b01000, 1'b1, 8'h02, 4'd7},  // R7
    '{1'b0, 4'h0, 4'b1111, 5'b00100, 1'b1, 8'h00, 4'd10}, // R10 thr shown
    '{1'b0, 4'h0, 4'b1111, 5'b00010, 1'b0, 8'h01, 4'd8},  // R8
    '{1'b0, 4'h0, 4'b0111, 5'b00000, 1'b0, 8'h01, 4'd4},  // R4
    '{1'b0, 4'h0, 4'b1111, 5'b00000, 1'b1, 8'h06, 4'd6},  // R6 re-armed
    '{1'b0, 4'h0, 4'b1111, 5'b10000, 1'b0, 8'h01, 4'd6},  // R6
    '{1'b0, 4'h0, 4'b0000, 5'b00000, 1'b0, 8'h01, 4'd4},  // R4
    '{1'b0, 4'h0, 4'b0010, 5'b00000, 1'b1, 8'h02, 4'd3},  // R3
    '{1'b0, 4'h0, 4'b0010, 5'b00001, 1'b0, 8'h01, 4'd9},  // R9 write
    '{1'b0, 4'h0, 4'b0010, 5'b00000, 1'b0, 8'h01, 4'd9},  // R9 stays masked
    '{1'b0, 4'h0, 4'b0000, 5'b00000, 1'b0, 8'h01, 4'd9},  // R9
    '{1'b0, 4'h0, 4'b0010, 5'b00000, 1'b1, 8'h02, 4'd9},  // R9 new empty
    '{1'b1, 4'h2, 4'b0011, 5'b00000, 1'b1, 8'h02, 4'd2},  // R2
    '{1'b1, 4'h0, 4'b0011, 5'b00000, 1'b0, 8'h01, 4'd11}, // R11 same edge
    '{1'b1, 4'hF, 4'b1000, 5'b10000, 1'b0, 8'h01, 4'd11}, // R11 service same edge
    '{1'b0, 4'h0, 4'b1000, 5'b00000, 1'b0, 8'h01, 4'd6}   // R6 still masked
  };

  task automatic check(input string req, input logic ai, input logic [7:0] ad,
                       input logic ei, input logic [7:0] ed);
    total++;
    if (ai !== ei || ad !== ed) begin
      bad++;
      $display("FAIL %s: irq=%0b iir=%02h expected irq=%0b iir=%02h", req, ai, ad, ei, ed);
    end
  endtask

  task automatic drive_idle();
    ien_we = 0; ien_din = 0;
    {line_err, rx_ready, tx_empty, msr_delta} = 4'b0000;
    {rd_lsr, rd_rbr, rd_iir, rd_msr, wr_thr} = 5'b00000;
  endtask

  initial begin
    #150000;
    bad++;
    total++;
    $display("FAIL watchdog: run hung");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    drive_idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", irq, iir, 1'b0, 8'h01);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 after release", irq, iir, 1'b0, 8'h01);

    for (int i = 0; i < NV; i++) begin
      ien_we = TBL[i].we;
      ien_din = TBL[i].din;
      {line_err, rx_ready, tx_empty, msr_delta} = TBL[i].cnd;
      {rd_lsr, rd_rbr, rd_iir, rd_msr, wr_thr} = TBL[i].svc;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", TBL[i].req, i), irq, iir, TBL[i].eirq, TBL[i].eiir);
    end

    // R1: reset in the middle of activity
    drive_idle();
    ien_we = 1; ien_din = 4'hF; rx_ready = 1;
    @(negedge clk);
    ien_we = 0;
    check("R3 rx before reset", irq, iir, 1'b1, 8'h04);
    #1 rst_n = 0;
    #1 check("R1 async clear", irq, iir, 1'b0, 8'h01);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 enables cleared by reset", irq, iir, 1'b0, 8'h01);

    // R2: single enable bit selects only its source
    ien_we = 1; ien_din = 4'b0100;
    {line_err, rx_ready, tx_empty, msr_delta} = 4'b1011;
    @(negedge clk);
    ien_we = 0;
    check("R2 rx only enabled, rx low", irq, iir, 1'b0, 8'h01);
    rx_ready = 1;
    @(negedge clk);
    check("R5 rx only enabled", irq, iir, 1'b1, 8'h04);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule